// File: doc/BRIEF.md
# Channel Address and Count Engine for a Legacy-Compatible DMA Controller

This block is the per-channel datapath of a legacy-compatible DMA controller. It keeps the channel's address and transfer counter and builds a 32-bit physical address from them. A peripheral raises a request, the engine asks the host for the bus, and on the host's grant it performs exactly one transfer. During that transfer it presents the physical address and an acknowledge to the peripheral. On the last transfer of a block it raises a terminal-count pulse. After that pulse it either reloads its starting values or masks itself.

The physical address is made of a 16-bit counter placed under a page value. Normally the counter wraps inside its page. Writing the upper page byte switches on a mode in which counter overflow and underflow carry into the page. Writing the lower page byte switches that mode off again, so software must write the upper byte last. A parameter selects a byte-wide channel, where the counter sits at address bits 15:0, or a word-wide channel, where it sits at bits 16:1 and page bit 0 is dropped. In pass-through (cascade) mode the engine only forwards request and grant and does no address work.

Software programs the engine through a write strobe, a 3-bit register selector and a 16-bit data word.

Top module: `dma_xfer_engine`

## Requirements
- R1: With WORD_CH=0, during each transfer phys_addr equals {upper page byte, lower page byte, current address}.
- R2: With WORD_CH=1, during each transfer phys_addr equals {upper page byte, lower page byte bits 7:1, current address, 1'b0}. Lower page bit 0 has no effect.
- R3: While carry mode is off, an address step from 0xFFFF up, or from 0x0000 down, wraps the 16-bit counter and leaves both page bytes unchanged.
- R4: Writing the upper page byte (reg_sel=3) turns carry mode on. Writing the lower page byte (reg_sel=2) turns it off. In carry mode, counter wrap moves the 16-bit page value by one page: +1/-1 on a byte channel, +2/-2 on a word channel.
- R5: Writing count C with reg_sel=1 yields exactly C+1 transfers. Each transfer lowers cur_cnt_o by one. tc is high for one cycle, together with dack, on the transfer made while the count is 0x0000.
- R6: Mode bit 5 (mode is written with reg_sel=4, bits 7:4 kept) selects the step direction: 0 increments the address after each transfer and 1 decrements it.
- R7: At tc with mode bit 4 set, the address and count reload from the values last written with reg_sel=0 and reg_sel=1, and the mask stays clear. With mode bit 4 clear, mask_o becomes 1 on the next cycle.
- R8: With mode bits 7:6 = 2'b11, hold_req follows dreq while the mask is clear, dack follows hold_ack, and the address and count do not change.
- R9: While mask_o is 1 (written with reg_sel=5, data bit 0), dreq raises no hold_req. Otherwise, one granted request gives exactly one transfer: hold_req is high until hold_ack is seen, dack is high for the single following cycle, and then a new request is needed.
- R10: After reset, mask_o=1, hold_req=0, dack=0, tc=0, phys_addr=0 and cur_cnt_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | 0 address, 1 count, 2 lower page, 3 upper page, 4 mode, 5 mask |
| reg_wdata | input | CNT_W | Write data; page and mode use the low bits |
| dreq | input | 1 | Peripheral transfer request |
| hold_ack | input | 1 | Host grant of the bus |
| hold_req | output | 1 | Bus request to the host |
| dack | output | 1 | Transfer acknowledge to the peripheral |
| tc | output | 1 | Terminal-count pulse |
| mask_o | output | 1 | Channel mask state |
| phys_addr | output | 2*PG_W+CNT_W | Physical address, valid while dack is high |
| cur_cnt_o | output | CNT_W | Current transfer count |

## Verification
The main path is driven with blocks that start just below 0xFFFF with carry off, carry on, and carry written in the wrong order. These cases separate a page that wraps from a page that carries, and show which page write wins. A down-counting block that crosses 0x0000 tells the step direction apart from the wrap behaviour. An auto-reload block that runs past its end separates reload from masking. A byte channel and a word channel receive the same stimulus with an odd lower page byte, which tells the shifted address layout apart from the plain one and shows that page bit 0 is dropped. Pass-through mode is run with every request and grant combination, and a masked channel is held under a constant request.

// File: rtl/dma_eng_pkg.sv
// Package: shared selector codes and sequencer states for the channel engine.
package dma_eng_pkg;

    typedef enum logic [2:0] {
        SEL_ADDR   = 3'd0,
        SEL_COUNT  = 3'd1,
        SEL_PGLO   = 3'd2,
        SEL_PGHI   = 3'd3,
        SEL_MODE   = 3'd4,
        SEL_MASK   = 3'd5
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } seq_st_e;

    // Kept mode bits 7:4: [3:2] kind, [1] down-count, [0] auto-reload
    localparam logic [1:0] KIND_PASS = 2'b11;

endpackage

// File: rtl/dma_page_unit.sv
// Page unit: holds the two page bytes and the carry-enable flag.
// Writing the lower byte clears carry mode; writing the upper byte sets it.
// Assumes carry_up and carry_dn are never both high.
module dma_page_unit #(
    parameter int PG_W    = 8,
    parameter int WORD_CH = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [PG_W-1:0]   wdata,
    input  logic              carry_up,
    input  logic              carry_dn,
    output logic [2*PG_W-1:0] page,
    output logic              carry_en
);
    localparam int PW = 2 * PG_W;
    localparam logic [PW-1:0] STEP = (WORD_CH != 0) ? PW'(2) : PW'(1);

    logic [PG_W-1:0] lo_q, hi_q;
    logic            en_q;

    // Page bytes: software writes take precedence over a carry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
            en_q <= 1'b0;
        end else if (lo_we) begin
            lo_q <= wdata;
            en_q <= 1'b0;
        end else if (hi_we) begin
            hi_q <= wdata;
            en_q <= 1'b1;
        end else if (carry_up) begin
            {hi_q, lo_q} <= {hi_q, lo_q} + STEP;
        end else if (carry_dn) begin
            {hi_q, lo_q} <= {hi_q, lo_q} - STEP;
        end
    end

    assign page     = {hi_q, lo_q};
    assign carry_en = en_q;
endmodule

// File: rtl/dma_addr_cnt.sv
// Address/count unit: base and current address and count registers.
// On each step the address moves by one, the count drops by one,
// or both reload from base. Assumes step is a single-cycle strobe.
module dma_addr_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_we,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             step,
    input  logic             dec,
    input  logic             reload,
    output logic [CNT_W-1:0] cur_addr,
    output logic [CNT_W-1:0] cur_cnt,
    output logic             wrap,
    output logic             cnt_zero
);
    logic [CNT_W-1:0] base_addr_q, cur_addr_q, base_cnt_q, cur_cnt_q;

    // Address registers: a write loads base and current together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr_q <= '0;
            cur_addr_q  <= '0;
        end else if (addr_we) begin
            base_addr_q <= wdata;
            cur_addr_q  <= wdata;
        end else if (step) begin
            if (reload)   cur_addr_q <= base_addr_q;
            else if (dec) cur_addr_q <= cur_addr_q - CNT_W'(1);
            else          cur_addr_q <= cur_addr_q + CNT_W'(1);
        end
    end

    // Count registers: decrement per transfer, reload at block end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt_q <= '0;
            cur_cnt_q  <= '0;
        end else if (cnt_we) begin
            base_cnt_q <= wdata;
            cur_cnt_q  <= wdata;
        end else if (step) begin
            if (reload) cur_cnt_q <= base_cnt_q;
            else        cur_cnt_q <= cur_cnt_q - CNT_W'(1);
        end
    end

    // The next step leaves the 16-bit range in the current direction
    always_comb begin
        wrap = dec ? (cur_addr_q == '0) : (&cur_addr_q);
    end

    assign cnt_zero = (cur_cnt_q == '0);
    assign cur_addr = cur_addr_q;
    assign cur_cnt  = cur_cnt_q;
endmodule

// File: rtl/dma_seq.sv
// Sequencer: request/grant handshake and mask flag.
// Normal mode: idle -> request -> one transfer cycle -> idle.
// Pass-through mode forwards request and grant combinationally.
module dma_seq
    import dma_eng_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dreq,
    input  logic hold_ack,
    input  logic pass_mode,
    input  logic mask_we,
    input  logic mask_wbit,
    input  logic end_mask,
    output logic hold_req,
    output logic dack,
    output logic xfer,
    output logic mask
);
    seq_st_e st_q, st_d;
    logic    mask_q;

    // Next-state logic for the handshake
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (dreq && !mask_q && !pass_mode) st_d = ST_REQ;
            ST_REQ:  if (hold_ack) st_d = ST_XFER;
            ST_XFER: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Mask flag: set at reset and at a non-reloading block end
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= 1'b1;
        else if (mask_we)  mask_q <= mask_wbit;
        else if (end_mask) mask_q <= 1'b1;
    end

    // Output decode for both modes
    always_comb begin
        xfer     = !pass_mode && (st_q == ST_XFER);
        hold_req = pass_mode ? (dreq && !mask_q) : (st_q == ST_REQ);
        dack     = pass_mode ? hold_ack : (st_q == ST_XFER);
    end

    assign mask = mask_q;
endmodule

// File: rtl/dma_xfer_engine.sv
// Top: one DMA channel engine. Holds the mode bits, wires the page,
// address/count and sequencer units, and forms the physical address
// for a byte-wide (WORD_CH=0) or word-wide (WORD_CH=1) channel.
// Assumes CNT_W >= 8 and PG_W <= CNT_W.
module dma_xfer_engine
    import dma_eng_pkg::*;
#(
    parameter int WORD_CH = 0,
    parameter int CNT_W   = 16,
    parameter int PG_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic [2:0]                reg_sel,
    input  logic [CNT_W-1:0]          reg_wdata,
    input  logic                      dreq,
    input  logic                      hold_ack,
    output logic                      hold_req,
    output logic                      dack,
    output logic                      tc,
    output logic                      mask_o,
    output logic [2*PG_W+CNT_W-1:0]   phys_addr,
    output logic [CNT_W-1:0]          cur_cnt_o
);
    localparam int PW = 2 * PG_W;

    reg_sel_e         sel;
    logic [3:0]       mode_q;
    logic             is_cascade, is_dec, is_auto;
    logic             xfer, wrap, cnt_zero, carry_en;
    logic [PW-1:0]    page;
    logic [CNT_W-1:0] cur_addr;

    assign sel = reg_sel_e'(reg_sel);

    // Mode register: keeps kind, direction and auto-reload bits
    always_ff @(posedge clk) begin
        if (!rst_n)                         mode_q <= '0;
        else if (reg_we && sel == SEL_MODE) mode_q <= reg_wdata[7:4];
    end

    assign is_cascade = (mode_q[3:2] == KIND_PASS);
    assign is_dec     = mode_q[1];
    assign is_auto    = mode_q[0];
    assign tc         = xfer && cnt_zero;

    dma_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dreq      (dreq),
        .hold_ack  (hold_ack),
        .pass_mode (is_cascade),
        .mask_we   (reg_we && sel == SEL_MASK),
        .mask_wbit (reg_wdata[0]),
        .end_mask  (tc && !is_auto),
        .hold_req  (hold_req),
        .dack      (dack),
        .xfer      (xfer),
        .mask      (mask_o)
    );

    dma_addr_cnt #(.CNT_W(CNT_W)) u_ac (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_we  (reg_we && sel == SEL_ADDR),
        .cnt_we   (reg_we && sel == SEL_COUNT),
        .wdata    (reg_wdata),
        .step     (xfer),
        .dec      (is_dec),
        .reload   (tc && is_auto),
        .cur_addr (cur_addr),
        .cur_cnt  (cur_cnt_o),
        .wrap     (wrap),
        .cnt_zero (cnt_zero)
    );

    dma_page_unit #(.PG_W(PG_W), .WORD_CH(WORD_CH)) u_pg (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_we    (reg_we && sel == SEL_PGLO),
        .hi_we    (reg_we && sel == SEL_PGHI),
        .wdata    (reg_wdata[PG_W-1:0]),
        .carry_up (xfer && wrap && carry_en && !is_dec),
        .carry_dn (xfer && wrap && carry_en && is_dec),
        .page     (page),
        .carry_en (carry_en)
    );

    // Physical address layout chosen by channel width
    generate
        if (WORD_CH != 0) begin : g_word
            assign phys_addr = {page[PW-1:1], cur_addr, 1'b0};
        end else begin : g_byte
            assign phys_addr = {page, cur_addr};
        end
    endgenerate
endmodule

// File: rtl/dma_xfer_checker.sv
// Checker: handshake, terminal-count and count-step properties of the engine.
module dma_xfer_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic             hold_req,
    input logic             hold_ack,
    input logic             dack,
    input logic             tc,
    input logic             mask,
    input logic [CNT_W-1:0] cnt,
    input logic             casc,
    input logic             autoinit
);
    AST_TC_WITH_DACK: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> dack);                                                   // R5
    AST_DACK_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && !casc) |-> $past(hold_req && hold_ack));               // R9
    AST_ONE_XFER_PER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && !casc) |=> !dack);                                     // R9
    AST_MASK_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !autoinit && !reg_we) |=> mask);                         // R7
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && !casc && !tc && !reg_we) |=> (cnt == $past(cnt) - CNT_W'(1))); // R5
endmodule

bind dma_xfer_engine dma_xfer_checker #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .hold_req (hold_req),
    .hold_ack (hold_ack),
    .dack     (dack),
    .tc       (tc),
    .mask     (mask_o),
    .cnt      (cur_cnt_o),
    .casc     (is_cascade),
    .autoinit (is_auto)
);

// File: tb/tb_dma_xfer_engine.sv
`timescale 1ns/1ps

// Behavioural reference channel used by the bench
module tb_ref_chan #(parameter int WORD = 0) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [2:0]  sel,
    input  logic [15:0] wd,
    input  logic        dreq,
    input  logic        ack,
    output logic        e_hreq,
    output logic        e_dack,
    output logic        e_tc,
    output logic        e_mask,
    output logic [31:0] e_phys
);
    int st, addr, cnt, baddr, bcnt, page, mode;
    bit hp, mask;
    logic casc;

    assign casc   = ((mode >> 6) & 3) == 3;
    assign e_tc   = !casc && st == 2 && cnt == 0;
    assign e_dack = casc ? ack : (st == 2);
    assign e_hreq = casc ? (dreq && !mask) : (st == 1);
    assign e_mask = mask;
    assign e_phys = WORD ? ((32'(page) >> 1) << 17) | (32'(addr) << 1)
                         : (32'(page) << 16) | 32'(addr);

    always @(posedge clk) begin : model
        int nst, stp;
        bit x, t, wrap, dec, aut, pgw;
        if (!rst_n) begin
            st = 0; addr = 0; cnt = 0; baddr = 0; bcnt = 0;
            page = 0; mode = 0; hp = 0; mask = 1;
        end else begin
            stp = WORD ? 2 : 1;
            x   = !casc && st == 2;
            t   = x && cnt == 0;
            dec = ((mode >> 5) & 1) == 1;
            aut = ((mode >> 4) & 1) == 1;
            if (st == 0)      nst = (dreq && !mask && !casc) ? 1 : 0;
            else if (st == 1) nst = ack ? 2 : 1;
            else              nst = 0;
            pgw = we && (sel == 2 || sel == 3);
            if (x) begin
                wrap = dec ? (addr == 0) : (addr == 65535);
                if (wrap && hp && !pgw) page = (page + (dec ? -stp : stp)) & 'hFFFF;
                if (t && aut) begin
                    addr = baddr; cnt = bcnt;
                end else begin
                    addr = (addr + (dec ? -1 : 1)) & 'hFFFF;
                    cnt  = (cnt - 1) & 'hFFFF;
                end
                if (t && !aut) mask = 1;
            end
            st = nst;
            if (we) begin
                case (sel)
                    3'd0: begin addr = int'(wd); baddr = int'(wd); end
                    3'd1: begin cnt = int'(wd); bcnt = int'(wd); end
                    3'd2: begin page = (page & 'hFF00) | (int'(wd) & 'hFF); hp = 0; end
                    3'd3: begin page = (page & 'hFF) | ((int'(wd) & 'hFF) << 8); hp = 1; end
                    3'd4: mode = int'(wd) & 'hFF;
                    3'd5: mask = wd[0];
                    default: ;
                endcase
            end
        end
    end
endmodule

module tb_dma_xfer_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic        dreq = 1'b0;
    logic        hold_ack = 1'b1;

    logic        hreq_b, dack_b, tc_b, mask_b, hreq_w, dack_w, tc_w, mask_w;
    logic [31:0] phys_b, phys_w;
    logic [15:0] cnt_b, cnt_w;
    logic        eh_b, ed_b, et_b, em_b, eh_w, ed_w, et_w, em_w;
    logic [31:0] ep_b, ep_w;

    int checks = 0, failures = 0, cycles = 0;
    int tc_seen = 0, dack_seen = 0, hreq_seen = 0;
    bit  pass_mode = 1'b0;
    logic [31:0] qb[$], qw[$];

    always #2 clk = ~clk;

    dma_xfer_engine #(.WORD_CH(0)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .dreq(dreq), .hold_ack(hold_ack),
        .hold_req(hreq_b), .dack(dack_b), .tc(tc_b), .mask_o(mask_b),
        .phys_addr(phys_b), .cur_cnt_o(cnt_b));

    dma_xfer_engine #(.WORD_CH(1)) dut_w (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .dreq(dreq), .hold_ack(hold_ack),
        .hold_req(hreq_w), .dack(dack_w), .tc(tc_w), .mask_o(mask_w),
        .phys_addr(phys_w), .cur_cnt_o(cnt_w));

    tb_ref_chan #(.WORD(0)) ref_b (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wd(reg_wdata),
        .dreq(dreq), .ack(hold_ack), .e_hreq(eh_b), .e_dack(ed_b),
        .e_tc(et_b), .e_mask(em_b), .e_phys(ep_b));

    tb_ref_chan #(.WORD(1)) ref_w (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wd(reg_wdata),
        .dreq(dreq), .ack(hold_ack), .e_hreq(eh_w), .e_dack(ed_w),
        .e_tc(et_w), .e_mask(em_w), .e_phys(ep_w));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_list(input logic [31:0] got[$], input logic [31:0] exp[$],
                            input string req);
        chk(got.size() >= exp.size(), req, got.size(), exp.size());
        foreach (exp[i]) begin
            if (i < got.size()) chk(got[i] == exp[i], req, got[i], exp[i]);
        end
    endtask

    // Per-clock comparison against the reference channels
    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            chk(hreq_b == eh_b, "R9 hold_req byte", hreq_b, eh_b);
            chk(dack_b == ed_b, "R9 dack byte", dack_b, ed_b);
            chk(tc_b == et_b, "R5 tc byte", tc_b, et_b);
            chk(mask_b == em_b, "R7 mask byte", mask_b, em_b);
            chk(hreq_w == eh_w, "R9 hold_req word", hreq_w, eh_w);
            chk(dack_w == ed_w, "R9 dack word", dack_w, ed_w);
            chk(tc_w == et_w, "R5 tc word", tc_w, et_w);
            chk(mask_w == em_w, "R7 mask word", mask_w, em_w);
            if (dack_b && !pass_mode) begin
                chk(phys_b == ep_b, "R1 phys byte", phys_b, ep_b);
                qb.push_back(phys_b);
                dack_seen++;
            end
            if (dack_w && !pass_mode) begin
                chk(phys_w == ep_w, "R2 phys word", phys_w, ep_w);
                qw.push_back(phys_w);
            end
            if (tc_b) tc_seen++;
            if (hreq_b) hreq_seen++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    // Program one block; carry_last writes the upper page byte last
    task automatic setup(input logic [15:0] a, input logic [15:0] c,
                         input logic [7:0] lo, input logic [7:0] hi,
                         input bit carry_last, input logic [7:0] md);
        wr(3'd4, {8'h00, md});
        wr(3'd0, a);
        wr(3'd1, c);
        if (carry_last) begin
            wr(3'd2, {8'h00, lo}); wr(3'd3, {8'h00, hi});
        end else begin
            wr(3'd3, {8'h00, hi}); wr(3'd2, {8'h00, lo});
        end
        qb.delete(); qw.delete(); tc_seen = 0;
        wr(3'd5, 16'h0000);
    endtask

    task automatic run_block();
        dreq = 1'b1;
        for (int i = 0; i < 400; i++) begin
            tick();
            if (mask_b && mask_w) break;
        end
        dreq = 1'b0;
        repeat (4) tick();
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] c0;
        int d0, h0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        @(negedge clk);
        chk(mask_b == 1'b1 && hreq_b == 1'b0 && dack_b == 1'b0 && tc_b == 1'b0,
            "R10 reset controls", {hreq_b, dack_b, tc_b, mask_b}, 32'h1);
        chk(phys_b == 32'h0 && cnt_b == 16'h0, "R10 reset address/count", phys_b, 32'h0);
        tick();

        // R1 R2 R3 R5: no carry, odd lower page, three transfers over 0xFFFF
        setup(16'hFFFE, 16'h0002, 8'h35, 8'h00, 1'b0, 8'h00);
        run_block();
        chk_list(qb, '{32'h0035FFFE, 32'h0035FFFF, 32'h00350000}, "R3 byte wrap in page");
        chk_list(qw, '{32'h0035FFFC, 32'h0035FFFE, 32'h00340000}, "R2 word layout page bit0 dropped");
        chk(qb.size() == 3, "R5 count 2 gives 3 transfers", qb.size(), 3);
        chk(tc_seen == 1, "R5 single tc pulse", tc_seen, 1);
        chk(mask_b == 1'b1, "R7 mask set at end", mask_b, 1);

        // R4: upper byte written last enables carry
        setup(16'hFFFF, 16'h0001, 8'h34, 8'h56, 1'b1, 8'h00);
        run_block();
        chk_list(qb, '{32'h5634FFFF, 32'h56350000}, "R4 byte carry into page");
        chk_list(qw, '{32'h5635FFFE, 32'h56360000}, "R4 word carry by two");

        // R4 R3: lower byte written last disables carry
        setup(16'hFFFF, 16'h0001, 8'h34, 8'h56, 1'b0, 8'h00);
        run_block();
        chk_list(qb, '{32'h5634FFFF, 32'h56340000}, "R4 lower write clears carry");
        chk_list(qw, '{32'h5635FFFE, 32'h56340000}, "R3 word wrap in page");

        // R6: down-counting across 0x0000
        setup(16'h0001, 16'h0002, 8'h12, 8'h00, 1'b0, 8'h20);
        run_block();
        chk_list(qb, '{32'h00120001, 32'h00120000, 32'h0012FFFF}, "R6 decrement");

        // R7: auto-reload keeps running with the mask clear
        setup(16'h0100, 16'h0001, 8'h00, 8'h00, 1'b0, 8'h10);
        dreq = 1'b1;
        for (int i = 0; i < 100 && qb.size() < 4; i++) tick();
        dreq = 1'b0;
        repeat (4) tick();
        chk_list(qb, '{32'h00000100, 32'h00000101, 32'h00000100, 32'h00000101}, "R7 reload");
        chk(mask_b == 1'b0, "R7 mask stays clear with reload", mask_b, 0);
        wr(3'd5, 16'h0001);

        // R9: masked channel ignores a standing request
        d0 = dack_seen; h0 = hreq_seen;
        wr(3'd4, 16'h0000);
        dreq = 1'b1;
        repeat (10) tick();
        dreq = 1'b0;
        chk(dack_seen == d0, "R9 masked no transfer", dack_seen, d0);
        chk(hreq_seen == h0, "R9 masked no hold_req", hreq_seen, h0);

        // R8: pass-through follows request and grant
        wr(3'd4, 16'h00C0);
        pass_mode = 1'b1;
        wr(3'd5, 16'h0000);
        c0 = cnt_b;
        for (int k = 0; k < 4; k++) begin
            dreq = k[0]; hold_ack = k[1];
            @(negedge clk);
            chk(hreq_b == k[0], "R8 hold_req follows dreq", hreq_b, k[0]);
            chk(dack_b == k[1], "R8 dack follows hold_ack", dack_b, k[1]);
            tick();
        end
        dreq = 1'b0; hold_ack = 1'b1;
        tick();
        chk(cnt_b == c0, "R8 count unchanged in pass-through", cnt_b, c0);
        wr(3'd5, 16'h0001);
        wr(3'd4, 16'h0000);
        pass_mode = 1'b0;
        repeat (2) tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule